// File: doc/BRIEF.md
# Page Translation Unit

This block turns a 32-bit virtual address into a physical address through a flat page table held inside the block. Pages are 4 KiB. The upper 20 bits of the address select a table entry. The lower 12 bits pass through untouched and sit under the frame number stored in that entry. A host loads or rewrites entries through a one-cycle write port. Requesters present an address together with an access kind (read, write or execute) on a valid/ready handshake.

Two clock edges after a request is accepted, the block returns one of two results. On success it gives the physical address. On failure it gives a fault code that says why the access was refused. Every response also reports the entry's referenced and modified bits as they stand after that access. On a successful access the block updates those bits in the table itself. The table depth is a parameter. A page number at or beyond that depth is treated like an absent page.

Top module: `pgx_translate`

## Requirements
- R1: Entry layout on the host write port: bit 25 present, bit 24 referenced, bit 23 modified, bit 22 read allowed, bit 21 write allowed, bit 20 execute allowed, bits 19:0 frame number. On success the physical address is {frame, vaddr[11:0]}, where vaddr[31:12] is the page number. Two examples: address 9000 through a page-2 entry holding frame 4 gives 17192, and 0x00025328 through frame 0x03004 gives 0x03004328.
- R2: A request is taken at a rising edge where req_valid and req_ready are both high. rsp_valid is high for one cycle, after the second rising edge from that acceptance. One request can be taken every cycle. req_ready is low during reset and high from the first edge after reset is released.
- R3: If the selected entry has its present bit clear, the response carries fault code 01 and physical address 0.
- R4: If the page number is at or beyond TBL_DEPTH, the response carries fault code 01. This holds whatever the aliased entry contains, and in this case rsp_ref and rsp_mod read 0.
- R5: Access code 00 (read) needs bit 22, code 01 (write) needs bit 21, and code 10 (execute) needs bit 20. A present entry without the needed bit gives fault code 10 and physical address 0.
- R6: Access code 11 is always refused with fault code 10 when the entry is present.
- R7: A successful access of any kind sets the entry's referenced bit. rsp_ref and rsp_mod report the entry's bits after the access.
- R8: Only a successful write sets the modified bit. Reads and executes leave it as it was.
- R9: A faulting access leaves the entry's status bits unchanged, and the response reports their stored values.
- R10: An absent entry takes precedence over a permission failure. Such an access gives fault code 01.
- R11: After reset every entry is absent and rsp_valid is low.
- R12: A request taken one cycle after another to the same entry sees the status bits written back by the earlier one.
- R13: A host write and a request to the same entry at the same edge: the request uses the newly written entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| host_we | input | 1 | Host entry write strobe |
| host_idx | input | clog2(TBL_DEPTH) | Entry index to write |
| host_entry | input | 26 | Entry value in the R1 layout |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 absent page, 10 permission |
| rsp_ref | output | 1 | Entry referenced bit after the access |
| rsp_mod | output | 1 | Entry modified bit after the access |

## Verification
The hardest case to reach from the ports is two accesses to one entry close enough together that the second reads the table before the first's status write-back has landed. A host rewrite arriving on the very edge a request reads the table is equally hard. The bench issues a write and then a read to the same page on consecutive cycles, and checks that the read reports the modified bit set by the write. It also drives a host write and a request for the same page in one cycle, and expects the translation to use the new frame. Fault cases are followed by a successful access to the same page. That later response shows the status bits the faulting access left behind.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int VA_W  = 32;
  localparam int OFS_W = 12;
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PFN_W = VA_W - OFS_W;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_ABSENT  = 2'b01,
    FLT_PERM    = 2'b10,
    FLT_UNUSED  = 2'b11
  } flt_e;

  typedef struct packed {
    logic             present;
    logic             refd;
    logic             mod;
    logic             may_rd;
    logic             may_wr;
    logic             may_ex;
    logic [PFN_W-1:0] frame;
  } pte_t;

  localparam int PTE_W = $bits(pte_t);

  function automatic logic [VPN_W-1:0] page_num(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFS_W];
  endfunction

  function automatic logic [OFS_W-1:0] page_ofs(input logic [VA_W-1:0] va);
    return va[OFS_W-1:0];
  endfunction

  function automatic logic [VA_W-1:0] join_addr(input logic [PFN_W-1:0] frame,
                                                 input logic [OFS_W-1:0] ofs);
    return {frame, ofs};
  endfunction

  function automatic logic perm_ok(input pte_t e, input acc_e acc);
    case (acc)
      ACC_RD:  return e.may_rd;
      ACC_WR:  return e.may_wr;
      ACC_EX:  return e.may_ex;
      default: return 1'b0;
    endcase
  endfunction

  function automatic pte_t touch(input pte_t e, input acc_e acc);
    pte_t n;
    n      = e;
    n.refd = 1'b1;
    if (acc == ACC_WR) n.mod = 1'b1;
    return n;
  endfunction
endpackage

// File: rtl/pgx_table.sv
module pgx_table
  import pgx_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  pte_t             host_data,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  pte_t             wb_data,
  input  logic [IDX_W-1:0] rd_idx,
  output pte_t             rd_data
);
  pte_t mem [DEPTH];

  // Host write is applied last so it wins over a status write-back.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wb_en)   mem[wb_idx]   <= wb_data;
      if (host_we) mem[host_idx] <= host_data;
    end
  end

  // Forwarding: a reader at the same edge sees what the table will hold.
  logic hit_host, hit_wb;
  assign hit_host = host_we && (host_idx == rd_idx);
  assign hit_wb   = wb_en && (wb_idx == rd_idx);

  always_comb begin
    if (hit_host)    rd_data = host_data;
    else if (hit_wb) rd_data = wb_data;
    else             rd_data = mem[rd_idx];
  end

  // R9: status write-back only ever targets a present entry
  a_r9_wb_only_present: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_data.present);
endmodule

// File: rtl/pgx_check.sv
module pgx_check
  import pgx_pkg::*;
(
  input  pte_t entry,
  input  acc_e acc,
  input  logic beyond,
  output flt_e fault,
  output logic grant,
  output pte_t entry_next
);
  always_comb begin
    if (beyond || !entry.present) fault = FLT_ABSENT;
    else if (!perm_ok(entry, acc)) fault = FLT_PERM;
    else fault = FLT_NONE;
  end

  assign grant      = (fault == FLT_NONE);
  assign entry_next = grant ? touch(entry, acc) : entry;
endmodule

// File: rtl/pgx_translate.sv
module pgx_translate
  import pgx_pkg::*;
#(
  parameter int TBL_DEPTH = 256,
  localparam int IDX_W = $clog2(TBL_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [25:0]      host_entry,
  output logic             rsp_valid,
  output logic [31:0]      rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             rsp_ref,
  output logic             rsp_mod
);
  localparam logic [VPN_W:0] DEPTH_V = (VPN_W + 1)'(TBL_DEPTH);

  logic ready_q;
  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign req_ready = ready_q;

  // Request decode
  logic             accept;
  logic [VPN_W-1:0] req_vpn;
  logic             req_beyond;
  logic [IDX_W-1:0] req_idx;
  assign accept     = req_valid && ready_q;
  assign req_vpn    = page_num(req_vaddr);
  assign req_beyond = ({1'b0, req_vpn} >= DEPTH_V);
  assign req_idx    = req_vpn[IDX_W-1:0];

  // Table and write-back path
  pte_t             rd_entry;
  logic             wb_en;
  pte_t             wb_entry;
  logic [IDX_W-1:0] s_idx;

  pgx_table #(.DEPTH(TBL_DEPTH)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_idx  (host_idx),
    .host_data (pte_t'(host_entry)),
    .wb_en     (wb_en),
    .wb_idx    (s_idx),
    .wb_data   (wb_entry),
    .rd_idx    (req_idx),
    .rd_data   (rd_entry)
  );

  // Stage: entry captured at the accepting edge
  logic             s_valid;
  pte_t             s_entry;
  logic [OFS_W-1:0] s_ofs;
  acc_e             s_acc;
  logic             s_beyond;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid  <= 1'b0;
      s_entry  <= '0;
      s_idx    <= '0;
      s_ofs    <= '0;
      s_acc    <= ACC_RD;
      s_beyond <= 1'b0;
    end else begin
      s_valid <= accept;
      if (accept) begin
        s_entry  <= rd_entry;
        s_idx    <= req_idx;
        s_ofs    <= page_ofs(req_vaddr);
        s_acc    <= acc_e'(req_acc);
        s_beyond <= req_beyond;
      end
    end
  end

  flt_e s_fault;
  logic s_grant;

  pgx_check u_check (
    .entry      (s_entry),
    .acc        (s_acc),
    .beyond     (s_beyond),
    .fault      (s_fault),
    .grant      (s_grant),
    .entry_next (wb_entry)
  );

  assign wb_en = s_valid && s_grant;

  // Response registers, loaded at the same edge as the write-back
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
      rsp_ref   <= 1'b0;
      rsp_mod   <= 1'b0;
    end else begin
      rsp_valid <= s_valid;
      if (s_valid) begin
        rsp_paddr <= s_grant ? join_addr(s_entry.frame, s_ofs) : '0;
        rsp_fault <= s_fault;
        rsp_ref   <= s_beyond ? 1'b0 : wb_entry.refd;
        rsp_mod   <= s_beyond ? 1'b0 : wb_entry.mod;
      end
    end
  end

  // R2: every response traces back to an acceptance two edges earlier
  a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(accept, 2));

  // R3: a refused access carries no address
  a_r3_no_addr_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));

  // R5: the unused fault code never appears
  a_r5_fault_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != FLT_UNUSED));

  // R7: a granted access always reports the referenced bit set
  a_r7_ref_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_NONE) |-> rsp_ref);

  // R4: a page number beyond the table is never granted
  a_r4_beyond_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_beyond) |=> (rsp_fault == FLT_ABSENT));
endmodule

// File: tb/tb_pgx_translate.sv
module tb_pgx_translate;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        host_we;
  logic [7:0]  host_idx;
  logic [25:0] host_entry;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        rsp_ref;
  logic        rsp_mod;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pgx_translate #(.TBL_DEPTH(256)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc),
    .host_we(host_we), .host_idx(host_idx), .host_entry(host_entry),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_ref(rsp_ref), .rsp_mod(rsp_mod)
  );

  // Vector: wr(1) idx(8) data(26) va(32) acc(2) fault(2) paddr(32) ref(1) mod(1)
  localparam logic [104:0] VECS [NV] = '{
    // R1 R7: page 2 -> frame 4, read
    {1'b1, 8'd2,    26'h2600004, 32'd9000,       2'd0, 2'd0, 32'd17192,     1'b1, 1'b0},
    // R8: write to same page sets modified
    {1'b0, 8'd0,    26'h0,       32'd9000,       2'd1, 2'd0, 32'd17192,     1'b1, 1'b1},
    // R1 R7: execute through frame 0x03004
    {1'b1, 8'h25,   26'h2703004, 32'h00025328,   2'd2, 2'd0, 32'h03004328,  1'b1, 1'b0},
    // R3: absent entry
    {1'b1, 8'd7,    26'h0600123, 32'h00007ABC,   2'd0, 2'd1, 32'h0,         1'b0, 1'b0},
    // R5 R9: write to read-only page
    {1'b1, 8'd9,    26'h2400055, 32'h00009010,   2'd1, 2'd2, 32'h0,         1'b0, 1'b0},
    // R5 R9: execute on read-only page
    {1'b0, 8'd0,    26'h0,       32'h00009010,   2'd2, 2'd2, 32'h0,         1'b0, 1'b0},
    // R9 R8: read shows no leftover from the faults
    {1'b0, 8'd0,    26'h0,       32'h00009FFF,   2'd0, 2'd0, 32'h00055FFF,  1'b1, 1'b0},
    // R4: page 256 aliases index 0 but is beyond the table
    {1'b1, 8'd0,    26'h2411111, 32'h00100000,   2'd0, 2'd1, 32'h0,         1'b0, 1'b0},
    // R1 R7: index 0 itself works
    {1'b0, 8'd0,    26'h0,       32'h00000ABC,   2'd0, 2'd0, 32'h11111ABC,  1'b1, 1'b0},
    // R5 R9: read without read right, preset modified kept
    {1'b1, 8'h0B,   26'h2BFFFFF, 32'h0000B000,   2'd0, 2'd2, 32'h0,         1'b0, 1'b1},
    // R1 R8: write succeeds
    {1'b0, 8'd0,    26'h0,       32'h0000B004,   2'd1, 2'd0, 32'hFFFFF004,  1'b1, 1'b1},
    // R6: code 11 refused
    {1'b0, 8'd0,    26'h0,       32'h0000B004,   2'd3, 2'd2, 32'h0,         1'b1, 1'b1},
    // R10: absent wins over permission
    {1'b1, 8'h0C,   26'h0000000, 32'h0000C000,   2'd3, 2'd1, 32'h0,         1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] idx, input logic [25:0] data);
    @(negedge clk);
    host_we = 1'b1; host_idx = idx; host_entry = data;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // Issue one request; check latency and the response fields.
  task automatic run_one(input string tag, input logic [31:0] va, input logic [1:0] acc,
                         input logic [1:0] ef, input logic [31:0] ep,
                         input logic er, input logic em);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 early"}, {31'b0, rsp_valid}, 32'd0);
    @(negedge clk);
    chk({tag, " R2 valid"}, {31'b0, rsp_valid}, 32'd1);
    chk({tag, " fault"}, {30'b0, rsp_fault}, {30'b0, ef});
    chk({tag, " paddr"}, rsp_paddr, ep);
    chk({tag, " ref"}, {31'b0, rsp_ref}, {31'b0, er});
    chk({tag, " mod"}, {31'b0, rsp_mod}, {31'b0, em});
    @(negedge clk);
    chk({tag, " R2 one cycle"}, {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_acc = '0;
    host_we = 1'b0; host_idx = '0; host_entry = '0;
    repeat (3) @(negedge clk);
    // R11 R2: reset state
    chk("R11 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    chk("R2 ready in reset", {31'b0, req_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ready after reset", {31'b0, req_ready}, 32'd1);
    // R11: entries come up absent
    run_one("R11 absent after reset", 32'h00003000, 2'd0, 2'd1, 32'h0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][104]) host_write(VECS[i][103:96], VECS[i][95:70]);
      run_one($sformatf("vector %0d", i), VECS[i][69:38], VECS[i][37:36],
              VECS[i][35:34], VECS[i][33:2], VECS[i][1], VECS[i][0]);
    end

    // R12: back-to-back write then read on page 0x20
    host_write(8'h20, 26'h2600321);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h00020010; req_acc = 2'd1;
    @(negedge clk);
    req_vaddr = 32'h00020020; req_acc = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 first valid", {31'b0, rsp_valid}, 32'd1);
    chk("R12 first paddr", rsp_paddr, 32'h00321010);
    chk("R12 first mod", {31'b0, rsp_mod}, 32'd1);
    @(negedge clk);
    chk("R12 second valid", {31'b0, rsp_valid}, 32'd1);
    chk("R12 second paddr", rsp_paddr, 32'h00321020);
    chk("R12 second ref", {31'b0, rsp_ref}, 32'd1);
    chk("R12 second mod kept", {31'b0, rsp_mod}, 32'd1);
    @(negedge clk);

    // R13: host write and request to page 0x30 on the same edge
    @(negedge clk);
    host_we = 1'b1; host_idx = 8'h30; host_entry = 26'h2400AAA;
    req_valid = 1'b1; req_vaddr = 32'h00030777; req_acc = 2'd0;
    @(negedge clk);
    host_we = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk("R13 valid", {31'b0, rsp_valid}, 32'd1);
    chk("R13 fault", {30'b0, rsp_fault}, 32'd0);
    chk("R13 paddr", rsp_paddr, 32'h00AAA777);
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule